// File: doc/BRIEF.md
# Looping Audio Ring DMA Channel

This block moves one audio stream through a circular buffer in memory, for playback or for capture. Software loads three registers: a buffer base address, a frame register and a sample register. The frame register holds the buffer size and the current read or write position. The sample register holds the block length and a countdown. Outside logic offers the channel a grant of up to some number of bytes. The channel turns the grant into one memory request, with a start address and a byte length. When the memory side reports how many bytes it moved, the channel advances its position and counts down what is left of the block.

The position is kept as a longword index plus a byte leftover of 0 to 3. This lets a transfer end on any byte boundary. The countdown is kept in samples, and the format sets how many bytes make one sample. When a block completes, the channel sends a one-cycle end-of-block pulse and reloads the countdown. In looping mode the index returns to zero after the last longword of the buffer. In one-shot mode the channel halts there.

The controller has three states. IDLE waits for a grant. BUSY holds a request until its completion arrives. HALT means a one-shot buffer has been used up. The transitions are:
- IDLE to BUSY, named ACCEPT: a grant arrives while the channel is running and the computed length is non-zero.
- BUSY to IDLE, named RETIRE: a completion is reported.
- BUSY to HALT, named EXHAUST: a completion in one-shot mode carries the index past the buffer end.
- HALT to IDLE, named REARM: software writes the frame register.

Top module: `aud_ring_dma`

## Requirements
- R1: After reset, the frame, sample and base registers read as zero, the state is IDLE, and req_valid, eob and stopped are all low.
- R2: A write with cfg_sel=0 loads the base address. A write with cfg_sel=1 loads the frame register (bits 31:16 are the index, bits 15:0 are the size minus one, both in longwords) and clears the leftover. A write with cfg_sel=2 loads the sample register (bits 31:16 are the countdown, bits 15:0 are the reload value, both in samples minus one).
- R3: fmt bit 0 selects stereo and fmt bit 1 selects 16-bit samples. The byte shift is fmt[0]+fmt[1]. The grant is rounded down to a multiple of 1<<shift.
- R4: The request length is the smallest of three values: the rounded grant; the buffer bytes left, which are (size-index+1)*4+leftover, or 0 when index>size; and the block bytes left, which are (countdown+1)<<shift. If this length is zero, the grant is ignored.
- R5: The request address is base+4*index+leftover. The address and the length stay unchanged while req_valid is high, until a completion arrives.
- R6: A completion is clamped to req_len. The index then grows by (bytes+leftover)>>2, and the leftover becomes (bytes+leftover)&3.
- R7: If the completed bytes equal the block bytes left, eob is high for exactly the next cycle and the countdown is reloaded. Otherwise the countdown becomes (blockbytes-bytes-1)>>shift.
- R8: With loop_off=0, an index that would pass the size becomes 0.
- R9: With loop_off=1, an index that would pass the size is stored as computed and the channel enters HALT: stopped is high and grants are ignored until the next frame register write.
- R10: While chan_en=0 or chan_pause=1, grants are ignored.
- R11: done_valid has no effect unless a request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 frame, 2 sample |
| cfg_wdata | input | 32 | Register write data |
| chan_en | input | 1 | Channel enable |
| chan_pause | input | 1 | Channel pause |
| loop_off | input | 1 | 1 = one-shot, 0 = looping |
| fmt | input | 2 | Sample format: bit0 stereo, bit1 16-bit |
| grant_valid | input | 1 | Grant offered this cycle |
| grant_bytes | input | GRANT_W | Bytes granted |
| req_valid | output | 1 | Memory request outstanding |
| req_addr | output | ADDR_W | Request start byte address |
| req_len | output | 19 | Request byte length |
| done_valid | input | 1 | Completion reported this cycle |
| done_bytes | input | 19 | Bytes actually moved |
| frame_q | output | 32 | Frame register {index, size} |
| sample_q | output | 32 | Sample register {countdown, reload} |
| eob | output | 1 | End-of-block pulse |
| stopped | output | 1 | One-shot buffer exhausted (HALT) |

## Verification
On every cycle, the assertions check these properties: a request never has length zero; a request starts only while the channel is running and a grant is offered; its length never exceeds that grant; the request stays stable while outstanding; every end-of-block pulse follows an accepted completion; and in looping mode the index stays inside the buffer. Only the bench scenarios can show the arithmetic itself. This covers the leftover carried across byte-odd transfers, the countdown after a partial completion, the reload and wrap at exact boundaries, the rounding of a grant for each format, and the halt and re-arm of one-shot mode. The reference model checks each of these every cycle.

// File: rtl/aud_ring_pkg.sv
package aud_ring_pkg;
    localparam int HALF_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_HALT = 2'd2
    } ring_state_e;

    localparam logic [1:0] SEL_BASE   = 2'd0;
    localparam logic [1:0] SEL_FRAME  = 2'd1;
    localparam logic [1:0] SEL_SAMPLE = 2'd2;

    // bytes per sample = 1 << shift
    function automatic logic [1:0] fmt_shift(input logic [1:0] f);
        return {1'b0, f[0]} + {1'b0, f[1]};
    endfunction
endpackage

// File: rtl/aud_ring_span.sv
// Computes the start address and the length of the next request.
module aud_ring_span
    import aud_ring_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int GRANT_W = 16,
    parameter int LEN_W   = HALF_W + 3
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [HALF_W-1:0]  idx,
    input  logic [HALF_W-1:0]  size,
    input  logic [HALF_W-1:0]  csc,
    input  logic [1:0]         lo,
    input  logic [1:0]         shift,
    input  logic [GRANT_W-1:0] grant,
    output logic [ADDR_W-1:0]  addr,
    output logic [LEN_W-1:0]   len,
    output logic [LEN_W-1:0]   need
);
    logic [LEN_W-1:0] left_w;
    logic [LEN_W-1:0] g_w;
    logic [LEN_W-1:0] m1;

    always_comb begin
        need = (LEN_W'(csc) + LEN_W'(1)) << shift;
        if (idx > size)
            left_w = '0;
        else
            left_w = ((LEN_W'(size) - LEN_W'(idx) + LEN_W'(1)) << 2) + LEN_W'(lo);
        g_w  = LEN_W'(grant) & ~((LEN_W'(1) << shift) - LEN_W'(1));
        m1   = (g_w < left_w) ? g_w : left_w;
        len  = (m1 < need) ? m1 : need;
        addr = base + ADDR_W'({idx, 2'b00}) + ADDR_W'(lo);
    end
endmodule

// File: rtl/aud_ring_advance.sv
// Computes the position and the countdown after a completion.
module aud_ring_advance
    import aud_ring_pkg::*;
#(
    parameter int LEN_W = HALF_W + 3,
    localparam int IW   = HALF_W + 1
) (
    input  logic [HALF_W-1:0] idx,
    input  logic [HALF_W-1:0] size,
    input  logic [1:0]        lo,
    input  logic [LEN_W-1:0]  need,
    input  logic [LEN_W-1:0]  bytes,
    input  logic [1:0]        shift,
    input  logic [HALF_W-1:0] sc,
    input  logic              loop_off,
    output logic [HALF_W-1:0] nidx,
    output logic [1:0]        nlo,
    output logic [HALF_W-1:0] ncsc,
    output logic              blk_done,
    output logic              past_end
);
    logic [LEN_W-1:0] tot;
    logic [LEN_W-1:0] rem;
    logic [IW-1:0]    n;

    always_comb begin
        tot      = bytes + LEN_W'(lo);
        n        = {1'b0, idx} + IW'(tot >> 2);
        nlo      = tot[1:0];
        past_end = n > {1'b0, size};
        blk_done = (bytes == need);
        rem      = need - bytes - LEN_W'(1);
        ncsc     = blk_done ? sc : HALF_W'(rem >> shift);
        if (past_end && !loop_off)
            nidx = '0;
        else
            nidx = n[HALF_W-1:0];
    end
endmodule

// File: rtl/aud_ring_dma.sv
module aud_ring_dma
    import aud_ring_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int GRANT_W = 16,
    localparam int LEN_W  = HALF_W + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [31:0]        cfg_wdata,
    input  logic               chan_en,
    input  logic               chan_pause,
    input  logic               loop_off,
    input  logic [1:0]         fmt,
    input  logic               grant_valid,
    input  logic [GRANT_W-1:0] grant_bytes,
    output logic               req_valid,
    output logic [ADDR_W-1:0]  req_addr,
    output logic [LEN_W-1:0]   req_len,
    input  logic               done_valid,
    input  logic [LEN_W-1:0]   done_bytes,
    output logic [31:0]        frame_q,
    output logic [31:0]        sample_q,
    output logic               eob,
    output logic               stopped
);
    ring_state_e state_q, state_d;

    logic [ADDR_W-1:0] base_q, addr_q;
    logic [HALF_W-1:0] idx_q, size_q, csc_q, sc_q;
    logic [1:0]        lo_q, shift_q;
    logic [LEN_W-1:0]  len_q, need_q;
    logic              eob_q;

    logic [1:0]        cur_shift;
    logic [ADDR_W-1:0] span_addr;
    logic [LEN_W-1:0]  span_len, span_need, bytes_c;
    logic [HALF_W-1:0] adv_idx, adv_csc;
    logic [1:0]        adv_lo;
    logic              adv_blk, adv_past;
    logic              grant_ok, done_ok, frame_wr;

    assign cur_shift = fmt_shift(fmt);

    aud_ring_span #(.ADDR_W(ADDR_W), .GRANT_W(GRANT_W), .LEN_W(LEN_W)) u_span (
        .base  (base_q),
        .idx   (idx_q),
        .size  (size_q),
        .csc   (csc_q),
        .lo    (lo_q),
        .shift (cur_shift),
        .grant (grant_bytes),
        .addr  (span_addr),
        .len   (span_len),
        .need  (span_need)
    );

    assign bytes_c = (done_bytes > len_q) ? len_q : done_bytes;

    aud_ring_advance #(.LEN_W(LEN_W)) u_adv (
        .idx      (idx_q),
        .size     (size_q),
        .lo       (lo_q),
        .need     (need_q),
        .bytes    (bytes_c),
        .shift    (shift_q),
        .sc       (sc_q),
        .loop_off (loop_off),
        .nidx     (adv_idx),
        .nlo      (adv_lo),
        .ncsc     (adv_csc),
        .blk_done (adv_blk),
        .past_end (adv_past)
    );

    assign grant_ok = (state_q == ST_IDLE) && grant_valid && chan_en && !chan_pause
                      && (span_len != '0);
    assign done_ok  = (state_q == ST_BUSY) && done_valid;
    assign frame_wr = cfg_we && (cfg_sel == SEL_FRAME);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (grant_ok) state_d = ST_BUSY;                       // ACCEPT
            ST_BUSY: if (done_ok)
                         state_d = (adv_past && loop_off) ? ST_HALT : ST_IDLE; // EXHAUST / RETIRE
            ST_HALT: if (frame_wr) state_d = ST_IDLE;                      // REARM
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            addr_q  <= '0;
            idx_q   <= '0;
            size_q  <= '0;
            csc_q   <= '0;
            sc_q    <= '0;
            lo_q    <= '0;
            shift_q <= '0;
            len_q   <= '0;
            need_q  <= '0;
            eob_q   <= 1'b0;
        end else begin
            eob_q <= 1'b0;
            if (grant_ok) begin
                addr_q  <= span_addr;
                len_q   <= span_len;
                need_q  <= span_need;
                shift_q <= cur_shift;
            end
            if (done_ok) begin
                idx_q <= adv_idx;
                lo_q  <= adv_lo;
                csc_q <= adv_csc;
                eob_q <= adv_blk;
            end
            if (cfg_we) begin
                case (cfg_sel)
                    SEL_BASE:   base_q <= ADDR_W'(cfg_wdata);
                    SEL_FRAME: begin
                        idx_q  <= cfg_wdata[31:16];
                        size_q <= cfg_wdata[15:0];
                        lo_q   <= 2'd0;
                    end
                    SEL_SAMPLE: begin
                        csc_q <= cfg_wdata[31:16];
                        sc_q  <= cfg_wdata[15:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        req_valid = (state_q == ST_BUSY);
        stopped   = (state_q == ST_HALT);
        req_addr  = addr_q;
        req_len   = len_q;
        eob       = eob_q;
        frame_q   = {idx_q, size_q};
        sample_q  = {csc_q, sc_q};
    end

    AST_REQ_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len != '0)); // R4
    AST_REQ_UNDER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> (32'(req_len) <= $past(32'(grant_bytes)))); // R4
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(req_valid) && !$past(done_valid)) |-> ($stable(req_addr) && $stable(req_len))); // R5
    AST_EOB_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        eob |-> $past(done_valid && req_valid)); // R7
    AST_LOOP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_valid && done_valid && !loop_off && !cfg_we)) |-> (frame_q[31:16] <= frame_q[15:0])); // R8
    AST_RUN_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> $past(chan_en && !chan_pause && grant_valid)); // R10
endmodule

// File: tb/aud_ring_dma_tb.sv
module aud_ring_dma_tb;
    localparam int LW = aud_ring_pkg::HALF_W + 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        chan_en = 1'b0, chan_pause = 1'b0, loop_off = 1'b0;
    logic [1:0]  fmt = 2'd0;
    logic        grant_valid = 1'b0;
    logic [15:0] grant_bytes = 16'd0;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [LW-1:0] req_len;
    logic        done_valid = 1'b0;
    logic [LW-1:0] done_bytes = '0;
    logic [31:0] frame_q, sample_q;
    logic        eob, stopped;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    longint m_base = 0, m_addr = 0;
    int m_idx = 0, m_size = 0, m_sc = 0, m_csc = 0, m_lo = 0;
    int m_st = 0, m_len = 0, m_need = 0, m_shf = 0;
    bit exp_eob = 0;

    always #4 clk = ~clk;

    aud_ring_dma u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .chan_en(chan_en), .chan_pause(chan_pause), .loop_off(loop_off), .fmt(fmt),
        .grant_valid(grant_valid), .grant_bytes(grant_bytes),
        .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
        .done_valid(done_valid), .done_bytes(done_bytes),
        .frame_q(frame_q), .sample_q(sample_q), .eob(eob), .stopped(stopped)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare();
        chk("R2/R6/R8 frame_q", 64'(frame_q), 64'({m_idx[15:0], m_size[15:0]}));
        chk("R7 sample_q", 64'(sample_q), 64'({m_csc[15:0], m_sc[15:0]}));
        chk("R4 req_valid", 64'(req_valid), 64'(m_st == 1));
        chk("R9 stopped", 64'(stopped), 64'(m_st == 2));
        chk("R7 eob", 64'(eob), 64'(exp_eob));
        if (m_st == 1) begin
            chk("R5 req_addr", 64'(req_addr), 64'(m_addr[31:0]));
            chk("R4 req_len", 64'(req_len), 64'(m_len));
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
        exp_eob = 0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        if (sel == 2'd0) m_base = longint'(d);
        else if (sel == 2'd1) begin
            m_idx = int'(d[31:16]); m_size = int'(d[15:0]); m_lo = 0;
            if (m_st == 2) m_st = 0;
        end else if (sel == 2'd2) begin
            m_csc = int'(d[31:16]); m_sc = int'(d[15:0]);
        end
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic grant(input int g);
        int s, gr, need, left, len;
        grant_valid = 1'b1; grant_bytes = 16'(g);
        if (m_st == 0 && chan_en && !chan_pause) begin
            s    = int'(fmt[0]) + int'(fmt[1]);
            gr   = (g / (1 << s)) * (1 << s);
            need = (m_csc + 1) * (1 << s);
            left = (m_idx > m_size) ? 0 : (m_size - m_idx + 1) * 4 + m_lo;
            len  = gr;
            if (left < len) len = left;
            if (need < len) len = need;
            if (len > 0) begin
                m_st = 1; m_len = len; m_need = need; m_shf = s;
                m_addr = (m_base + longint'(m_idx) * 4 + longint'(m_lo)) & 64'hFFFF_FFFF;
            end
        end
        tick();
        grant_valid = 1'b0;
    endtask

    task automatic done(input int d);
        int b, tot, n;
        done_valid = 1'b1; done_bytes = LW'(d);
        if (m_st == 1) begin
            b   = (d > m_len) ? m_len : d;
            tot = b + m_lo;
            n   = m_idx + tot / 4;
            m_lo = tot % 4;
            if (b == m_need) begin exp_eob = 1; m_csc = m_sc; end
            else m_csc = (m_need - b - 1) >> m_shf;
            if (n > m_size) begin
                if (loop_off) begin m_idx = n % 65536; m_st = 2; end
                else begin m_idx = 0; m_st = 0; end
            end else begin
                m_idx = n; m_st = 0;
            end
        end
        tick();
        done_valid = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        int seed;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 frame reset", 64'(frame_q), 64'd0);
        chk("R1 sample reset", 64'(sample_q), 64'd0);
        chk("R1 idle outputs", 64'({req_valid, eob, stopped}), 64'd0);

        chan_en = 1'b1; fmt = 2'd0; loop_off = 1'b0;
        wr(2'd0, 32'h0000_1000);
        wr(2'd1, 32'h0000_0003);            // size 4 longwords, index 0
        wr(2'd2, 32'h0007_0007);            // 8-sample blocks
        grant(5);
        chk("R5 first addr", 64'(req_addr), 64'h1000);
        chk("R4 first len", 64'(req_len), 64'd5);
        done(5);
        grant(10);
        chk("R5 leftover addr", 64'(req_addr), 64'h1005);
        chk("R4 block limit", 64'(req_len), 64'd3);
        done(3);                             // R7 end of block
        chk("R6 index after carry", 64'(frame_q), 64'h0002_0003);
        grant(100);
        done(8);                             // R8 wrap to 0
        chk("R8 wrap index", 64'(frame_q), 64'h0000_0003);
        tick();

        // R6 clamp and partial completion
        grant(6); done(20);
        grant(6); done(1);
        chk("R7 partial countdown", 64'(sample_q[31:16]), 64'(m_csc));

        // R11 completion while idle
        done(4);
        // R10 pause and disable
        chan_pause = 1'b1; grant(8);
        chk("R10 paused", 64'(req_valid), 64'd0);
        chan_pause = 1'b0; chan_en = 1'b0; grant(8);
        chk("R10 disabled", 64'(req_valid), 64'd0);
        chan_en = 1'b1;

        // R3 16-bit stereo rounding
        fmt = 2'd3;
        wr(2'd1, 32'h0000_0007);
        wr(2'd2, 32'h0003_0003);
        grant(7);
        chk("R3 rounded grant", 64'(req_len), 64'd4);
        done(4);
        grant(3);                            // R4 zero length ignored
        chk("R4 zero length", 64'(req_valid), 64'd0);

        // R9 one-shot end
        fmt = 2'd0; loop_off = 1'b1;
        wr(2'd2, 32'h0064_0064);
        wr(2'd1, 32'h0006_0007);
        grant(64); done(8);
        chk("R9 halted", 64'(stopped), 64'd1);
        grant(16);
        chk("R9 grant ignored", 64'(req_valid), 64'd0);
        wr(2'd1, 32'h0000_0007);
        chk("R9 rearm", 64'(stopped), 64'd0);
        loop_off = 1'b0;

        // mixed traffic in looping mode
        seed = 7;
        wr(2'd1, 32'h0000_0009);
        wr(2'd2, 32'h000B_000B);
        for (int i = 0; i < 400; i++) begin
            seed = (seed * 1103515245 + 12345) & 32'h7FFF_FFFF;
            fmt = 2'(seed >> 8);
            grant((seed >> 12) % 70);
            if (m_st == 1) begin
                if (((seed >> 20) & 3) == 0) done((seed >> 4) % 9);
                else done(m_len);
            end
        end
        repeat (2) tick();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule